// File: doc/BRIEF.md
# Six-mode interval counter

This block is one programmable down-counter channel. Software picks one of six behaviours through a 3-bit mode field and then writes an initial count through a load strobe. The count steps down once per clock while it runs. A gate input and a single output pin give the mode's waveform: a level change at terminal count, a retriggerable one-shot pulse, a periodic strobe, a square wave, or a one-clock strobe that is started either by the load itself or by a rising gate edge.

The mode and load inputs are plain control strobes sampled on the clock. There is no data stream and no handshake, so a strobe is always taken in the cycle it is high. If both arrive together, the mode write wins and the load is dropped. The width of the counter is the parameter `CNT_W`, 16 by default. A loaded value of zero stands for 2^CNT_W clocks.

Mode codes: 0 level on terminal count, 1 gate-triggered one-shot, 2 periodic strobe, 3 square wave, 4 load-started strobe, 5 gate-started strobe. Codes 6 and 7 are taken as 2 and 3. In the timings below, the start edge is the clock edge that samples `load_wr` high in modes 0, 2, 3 and 4. In modes 1 and 5 it is the first edge that samples `gate` high after it was sampled low, once a count has been loaded. N is the loaded count.

Top module: `interval_timer`

## Requirements
- R1: After reset `tmr_out` is 0, the channel is in mode 0 and no count runs. A load with no mode write behaves as mode 0.
- R2: A mode write stops counting and sets `tmr_out` to 0 for mode 0 and to 1 for every other code. Codes 6 and 7 act as modes 2 and 3.
- R3: In mode 0 a load drives `tmr_out` low at the start edge. It rises exactly N edges later and stays high until the next load, which drives it low again.
- R4: In mode 0, each edge that samples `gate` low does not count, which delays the rise by that many edges. The gate has no such effect in the other modes.
- R5: In mode 1 a load alone leaves `tmr_out` high. A trigger drives it low at the start edge, and it rises N edges later. A new trigger during the pulse restarts the N-edge interval.
- R6: In mode 2 `tmr_out` is high except for one clock cycle every N edges, with the first low cycle after the edge N edges from the start. The count reloads itself.
- R7: In mode 3 `tmr_out` repeats a period of N edges: high for ceil(N/2) and then low for floor(N/2), starting high at the start edge.
- R8: In mode 4 `tmr_out` stays high after the load, goes low for exactly one clock cycle after the edge N edges from the start, and then stays high.
- R9: In mode 5 a load alone does not start counting. A trigger starts it, and `tmr_out` goes low for one clock cycle N edges later. A new trigger before then restarts the interval.
- R10: A loaded count of 0 counts as 2^CNT_W edges in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode code taken on mode_wr |
| load_wr | input | 1 | Count load strobe |
| load_val | input | CNT_W | Initial count taken on load_wr |
| gate | input | 1 | Gate level (mode 0 enable, trigger in modes 1 and 5) |
| tmr_out | output | 1 | Counter output pin |

## Verification
The bench builds the channel with `CNT_W` = 8. This brings the zero-means-full-range case within a few hundred cycles, so the 256-edge interval of a zero load is checked to the exact edge in mode 0 and mode 4. All the other vectors use small counts: even and odd values in the square wave, a count of 1 at the single-step boundary, and retriggers placed before the terminal edge. Together these show every mode's waveform, edge by edge, over more than one period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    TM_TC_LEVEL  = 3'd0,
    TM_ONESHOT   = 3'd1,
    TM_RATE      = 3'd2,
    TM_SQUARE    = 3'd3,
    TM_SW_STROBE = 3'd4,
    TM_HW_STROBE = 3'd5
  } tmode_e;

  // Codes 6 and 7 fold onto the periodic modes.
  function automatic tmode_e norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return tmode_e'({1'b0, code[1:0]});
    return tmode_e'(code);
  endfunction
endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_sel,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             gate,
  input  logic             gate_rise,
  output tmode_e           mode_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] init_q,
  output logic             start_ev,
  output logic             term_ev,
  output logic             half_ev
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] HALF_FS = {1'b1, {(CNT_W-1){1'b0}}};

  logic running_q, armed_q;
  logic trig_mode, reload_mode, load_start, trig_start, gate_ok, tick;
  logic [CNT_W-1:0] start_val, half_v, half_thr;

  assign trig_mode   = (mode_q == TM_ONESHOT) || (mode_q == TM_HW_STROBE);
  assign reload_mode = (mode_q == TM_RATE) || (mode_q == TM_SQUARE);
  assign load_start  = load_wr & ~trig_mode;
  assign trig_start  = gate_rise & armed_q & trig_mode;
  assign start_ev    = ~mode_wr & (load_start | trig_start);
  assign start_val   = load_wr ? load_val : init_q;

  // Gate level only enables counting in the level-on-terminal mode.
  assign gate_ok = (mode_q != TM_TC_LEVEL) | gate;
  assign tick    = running_q & ~mode_wr & ~start_ev & gate_ok;
  assign term_ev = tick & (cnt_q == ONE);

  // A zero initial count means full range, so its half is the top bit.
  assign half_v   = (init_q == '0) ? HALF_FS : (init_q >> 1);
  assign half_thr = half_v + ONE;
  assign half_ev  = tick & (mode_q == TM_SQUARE) & (cnt_q == half_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= TM_TC_LEVEL;
      cnt_q     <= '0;
      init_q    <= '0;
      running_q <= 1'b0;
      armed_q   <= 1'b0;
    end else if (mode_wr) begin
      mode_q    <= norm_mode(mode_sel);
      running_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (load_wr) begin
        init_q <= load_val;
        if (trig_mode) armed_q <= 1'b1;
      end
      if (start_ev) begin
        cnt_q     <= start_val;
        running_q <= 1'b1;
      end else if (tick) begin
        if (term_ev && reload_mode) cnt_q <= init_q;
        else                        cnt_q <= cnt_q - ONE;
        if (term_ev && !reload_mode) running_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_out_shaper.sv
module tmr_out_shaper
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_sel,
  input  tmode_e     mode_q,
  input  logic       start_ev,
  input  logic       term_ev,
  input  logic       half_ev,
  output logic       out_q
);
  logic out_d;

  always_comb begin
    out_d = out_q;
    if (mode_wr) begin
      out_d = (mode_sel != 3'd0);
    end else begin
      case (mode_q)
        TM_TC_LEVEL, TM_ONESHOT: begin
          if (start_ev)     out_d = 1'b0;
          else if (term_ev) out_d = 1'b1;
        end
        TM_SQUARE: begin
          if (start_ev || term_ev) out_d = 1'b1;
          else if (half_ev)        out_d = 1'b0;
        end
        default: out_d = ~term_ev;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_sel,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             gate,
  output logic             tmr_out
);
  tmode_e           mode_q;
  logic [CNT_W-1:0] cnt_q, init_q;
  logic             gate_rise, start_ev, term_ev, half_ev;

  tmr_gate_edge u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate), .gate_rise(gate_rise)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .load_wr(load_wr), .load_val(load_val), .gate(gate),
    .gate_rise(gate_rise), .mode_q(mode_q), .cnt_q(cnt_q),
    .init_q(init_q), .start_ev(start_ev), .term_ev(term_ev),
    .half_ev(half_ev)
  );

  tmr_out_shaper u_out (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .mode_q(mode_q), .start_ev(start_ev), .term_ev(term_ev),
    .half_ev(half_ev), .out_q(tmr_out)
  );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [2:0]       mode_sel,
  input logic             load_wr,
  input logic             gate,
  input logic             tmr_out,
  input logic [2:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] init_q,
  input logic             start_ev,
  input logic             term_ev,
  input logic             half_ev
);
  assert_mode_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (tmr_out == ($past(mode_sel) != 3'd0)));

  assert_tc_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && term_ev) |=> tmr_out);

  assert_tc_stays_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && tmr_out && !mode_wr && !load_wr) |=> tmr_out);

  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && !gate && !mode_wr && !load_wr) |=> $stable(cnt_q));

  assert_oneshot_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 && start_ev) |=> !tmr_out);

  assert_rate_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && term_ev) |=> (cnt_q == $past(init_q)));

  assert_square_low_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd3 && half_ev && !term_ev) |=> !tmr_out);

  assert_strobe_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {3'd4, 3'd5} && !tmr_out) |-> $past(tmr_out));
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
  .load_wr(load_wr), .gate(gate), .tmr_out(tmr_out), .mode_q(mode_q),
  .cnt_q(cnt_q), .init_q(init_q), .start_ev(start_ev),
  .term_ev(term_ev), .half_ev(half_ev)
);

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/1ps
module interval_timer_tb_top;
  localparam int W    = 8;
  localparam int FULL = 1 << W;
  localparam int NV   = 13;
  // Fields: mode[20:18], count[17:10], observed edges[9:0]
  localparam logic [20:0] VECS [NV] = '{
    {3'd0, 8'd5, 10'd9},  {3'd0, 8'd1, 10'd4},  {3'd1, 8'd4, 10'd8},
    {3'd1, 8'd1, 10'd3},  {3'd2, 8'd4, 10'd13}, {3'd2, 8'd3, 10'd10},
    {3'd3, 8'd5, 10'd16}, {3'd3, 8'd4, 10'd13}, {3'd4, 8'd6, 10'd10},
    {3'd5, 8'd3, 10'd8},  {3'd0, 8'd0, 10'd260}, {3'd4, 8'd0, 10'd259},
    {3'd2, 8'd2, 10'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0, load_wr = 1'b0, gate = 1'b1;
  logic [2:0] mode_sel = '0;
  logic [W-1:0] load_val = '0;
  logic tmr_out;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  interval_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .load_wr(load_wr), .load_val(load_val), .gate(gate), .tmr_out(tmr_out)
  );

  task automatic chk(input logic exp, input string req);
    n_vec++;
    if (tmr_out !== exp) begin
      n_bad++;
      $display("FAIL %s: tmr_out=%b expected %b at %0t", req, tmr_out, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    mode_sel = 3'(m); mode_wr = 1'b1; step(); mode_wr = 1'b0;
  endtask

  task automatic load(input int v);
    load_val = W'(v); load_wr = 1'b1; step(); load_wr = 1'b0;
  endtask

  // Expected pin level k edges after the start edge.
  function automatic logic exp_out(input int m, input int n, input int k);
    int neff = (n == 0) ? FULL : n;
    case (m)
      0, 1:    return k >= neff;
      2:       return !(k > 0 && (k % neff) == 0);
      3:       return (k % neff) < ((neff + 1) / 2);
      default: return k != neff;
    endcase
  endfunction

  function automatic string req_of(input int m, input int n);
    if (n == 0) return "R10";
    case (m)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b0, "R1");
    rst_n = 1'b1;
    step();
    chk(1'b0, "R1");
    // Default mode after reset is mode 0: out rises two edges after load.
    load(2); chk(1'b0, "R1");
    step(); chk(1'b0, "R1");
    step(); chk(1'b1, "R1");

    for (int i = 0; i < NV; i++) begin
      int m   = int'(VECS[i][20:18]);
      int n   = int'(VECS[i][17:10]);
      int len = int'(VECS[i][9:0]);
      string req = req_of(m, n);
      gate = (m == 1 || m == 5) ? 1'b0 : 1'b1;
      step();
      set_mode(m);
      chk(m != 0, "R2");
      load(n);
      if (m == 1 || m == 5) begin
        chk(1'b1, req); step(); chk(1'b1, req);
        gate = 1'b1; step();
      end
      chk(exp_out(m, n, 0), req);
      for (int k = 1; k <= len; k++) begin
        step(); chk(exp_out(m, n, k), req);
      end
    end

    // R4: gate low for three edges delays the mode 0 rise by three.
    gate = 1'b1; set_mode(0); load(4);
    step(); step(); gate = 1'b0;
    step(); step(); step(); chk(1'b0, "R4");
    gate = 1'b1; step(); chk(1'b0, "R4");
    step(); chk(1'b1, "R4");
    // R3: a new load drives the output low again.
    load(3); chk(1'b0, "R3");
    step(); step(); chk(1'b0, "R3");
    step(); chk(1'b1, "R3");

    // R5: retrigger at T+3 stretches the one-shot to T+7.
    gate = 1'b0; step(); set_mode(1); load(4);
    gate = 1'b1; step(); chk(1'b0, "R5");
    step(); chk(1'b0, "R5");
    gate = 1'b0; step(); chk(1'b0, "R5");
    gate = 1'b1; step(); chk(1'b0, "R5");
    step(); chk(1'b0, "R5"); step(); chk(1'b0, "R5");
    step(); chk(1'b0, "R5"); step(); chk(1'b1, "R5");

    // R9: retrigger at T+3 moves the strobe from T+3 to T+6.
    gate = 1'b0; step(); set_mode(5); load(3);
    gate = 1'b1; step(); chk(1'b1, "R9");
    step(); chk(1'b1, "R9");
    gate = 1'b0; step(); chk(1'b1, "R9");
    gate = 1'b1; step(); chk(1'b1, "R9");
    step(); chk(1'b1, "R9"); step(); chk(1'b1, "R9");
    step(); chk(1'b0, "R9"); step(); chk(1'b1, "R9");

    // R2: code 6 acts as mode 2, code 7 as mode 3.
    set_mode(6); chk(1'b1, "R2");
    load(3); chk(1'b1, "R2");
    step(); chk(1'b1, "R2"); step(); chk(1'b1, "R2");
    step(); chk(1'b0, "R2"); step(); chk(1'b1, "R2");
    set_mode(7); load(4); chk(1'b1, "R2");
    step(); chk(1'b1, "R2"); step(); chk(1'b0, "R2");
    step(); chk(1'b0, "R2"); step(); chk(1'b1, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule